// File: doc/BRIEF.md
# Indirect-Access Network Controller Register Bank

This block is the host-side register file of a descriptor-driven Ethernet controller. The host sees only two 16-bit word locations: a pointer location and a data location. The pointer selects one of four internal registers, and the data location reads or writes whichever register the pointer selects. Any other word offset in the block's window reads as zero, and writes to it are dropped.

Register 0 is the run-control and status word. It holds sticky event bits that the host clears by writing ones. It also holds two summary bits (error and interrupt) that are recomputed whenever the host writes the register. A stop command overrides every other field of the write. Init and start commands are mutually exclusive, and init wins. Registers 1 and 2 hold the low and high halves of a 32-bit initialisation-block address. Register 3 is a plain mode word.

The receive and transmit ring engines report finished frames through single-cycle set strobes. A registered interrupt request follows the interrupt-summary and interrupt-enable bits.

Top module: `nic_csr_bank`

## Requirements
- R1: After reset, register 0 reads 0x0004, the pointer reads 0, registers 1 to 3 read 0, `init_ptr` is 0 and `irq` is low.
- R2: A read at word offset 0 returns the register the pointer selects. A read at offset 1 returns the pointer, zero-extended. Reads at offsets 2 and 3 return 0.
- R3: A write at offset 1 loads the pointer only when the written value is below 4. Otherwise the pointer keeps its value.
- R4: A register-0 write with bit 2 set makes register 0 exactly 0x0004, whatever the other written bits and the event strobes are in that cycle.
- R5: In a register-0 write without bit 2, each 1 in written bits 14..8 clears that bit. A 0 in those positions leaves the bit unchanged.
- R6: After those clears, bit 15 becomes the OR of bits 14, 13, 12 and 8, and bit 7 becomes the OR of bits 14..8.
- R7: In a register-0 write without bit 2, bit 6 (interrupt enable) takes the written value.
- R8: A register-0 write with bit 0 set (and bit 2 clear) sets bits 0 and 8 and clears bit 2. It ignores bit 1. Summary bits are not recomputed after this set, so init from the stopped state gives 0x0101 (plus bit 6 if written).
- R9: A register-0 write with bit 1 set, and bits 0 and 2 clear, sets bits 1, 5 and 4 and clears bit 2. Outputs `stopped`, `rx_on` and `tx_on` mirror bits 2, 5 and 4.
- R10: Data writes with the pointer at 1 or 2 load `init_ptr[15:0]` or `init_ptr[31:16]`. With the pointer at 3, the write is stored in the mode word, which drives `mode_cfg`. All three read back as written.
- R11: While bit 2 is clear, `rx_int_set` sets bit 10 and `tx_int_set` sets bit 9, each together with bit 7, in the next register state. This takes priority over a host clear of the same bit in that cycle. While bit 2 is set, the strobes have no effect.
- R12: `irq` is high in a cycle exactly when bits 7 and 6 of register 0 were both set in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for this cycle |
| host_addr | input | ADDR_W | Host word offset (0 data, 1 pointer) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr` (combinational) |
| rx_int_set | input | 1 | Receive-done event strobe |
| tx_int_set | input | 1 | Transmit-done event strobe |
| stopped | output | 1 | Register 0 bit 2 |
| rx_on | output | 1 | Register 0 bit 5 |
| tx_on | output | 1 | Register 0 bit 4 |
| init_ptr | output | 32 | Initialisation-block address from registers 2 and 1 |
| mode_cfg | output | 16 | Mode word (register 3) |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench checks stop writes that also carry init, start or clear bits together with event strobes. A design that let any of these through would leave stray bits beside 0x0004. It checks init immediately followed by start, where bit 8 must raise the error summary only on the second write. A design that recomputes summaries after the command sets would show bit 7 too early. It also checks a host clear that collides with a set strobe, and strobes that arrive while the block is stopped. A wrong priority would lose or invent an event. Out-of-range pointer writes and the one-cycle interrupt lag are checked on every clock against a behavioural model under random traffic.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
    localparam int DW        = 16;
    localparam int CSR_COUNT = 4;
    localparam int SEL_W     = $clog2(CSR_COUNT);

    localparam int B_ERR   = 15;
    localparam int B_RXI   = 10;
    localparam int B_TXI   = 9;
    localparam int B_IDONE = 8;
    localparam int B_INTR  = 7;
    localparam int B_IEN   = 6;
    localparam int B_RXON  = 5;
    localparam int B_TXON  = 4;
    localparam int B_STOP  = 2;
    localparam int B_START = 1;
    localparam int B_INIT  = 0;

    localparam logic [DW-1:0] W1C_MASK  = 16'h7F00;
    localparam logic [DW-1:0] ERR_MASK  = 16'h7100;
    localparam logic [DW-1:0] INTR_MASK = 16'h7F00;
    localparam logic [DW-1:0] STOP_VAL  = 16'h0004;

    typedef struct packed {
        logic [DW-1:0] csr0;
        logic          irq;
    } status_st_t;
endpackage

// File: rtl/nic_csr_status.sv
module nic_csr_status
    import nic_csr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          rx_set,
    input  logic          tx_set,
    output logic [DW-1:0] csr0_q,
    output logic          irq_q
);
    status_st_t st_d, st_q;
    logic [DW-1:0] work;
    logic          stop_cmd;

    always_comb begin
        st_d     = st_q;
        work     = st_q.csr0;
        stop_cmd = wr_en && wdata[B_STOP];
        if (wr_en && !stop_cmd) begin
            work         = st_q.csr0 & ~(wdata & W1C_MASK);
            work[B_ERR]  = |(work & ERR_MASK);
            work[B_INTR] = |(work & INTR_MASK);
            work[B_IEN]  = wdata[B_IEN];
            if (wdata[B_INIT]) begin
                work[B_INIT]  = 1'b1;
                work[B_IDONE] = 1'b1;
                work[B_STOP]  = 1'b0;
            end else if (wdata[B_START]) begin
                work[B_START] = 1'b1;
                work[B_RXON]  = 1'b1;
                work[B_TXON]  = 1'b1;
                work[B_STOP]  = 1'b0;
            end
        end
        if (!stop_cmd && !st_q.csr0[B_STOP]) begin
            if (rx_set) begin
                work[B_RXI]  = 1'b1;
                work[B_INTR] = 1'b1;
            end
            if (tx_set) begin
                work[B_TXI]  = 1'b1;
                work[B_INTR] = 1'b1;
            end
        end
        st_d.csr0 = stop_cmd ? STOP_VAL : work;
        st_d.irq  = st_q.csr0[B_INTR] & st_q.csr0[B_IEN];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.csr0 <= STOP_VAL;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign csr0_q = st_q.csr0;
    assign irq_q  = st_q.irq;
endmodule

// File: rtl/nic_csr_aux.sv
module nic_csr_aux
    import nic_csr_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ptr_wr,
    input  logic                          data_wr,
    input  logic [DW-1:0]                 wdata,
    output logic [SEL_W-1:0]              sel_q,
    output logic [CSR_COUNT-1:1][DW-1:0]  regs_q
);
    logic [SEL_W-1:0]             sel_d;
    logic [CSR_COUNT-1:1][DW-1:0] regs_d;
    logic [CSR_COUNT-1:1]         reg_we;

    for (genvar i = 1; i < CSR_COUNT; i++) begin : g_we
        assign reg_we[i] = data_wr && (sel_q == SEL_W'(i));
    end

    always_comb begin
        sel_d  = sel_q;
        regs_d = regs_q;
        if (ptr_wr && (32'(wdata) < CSR_COUNT)) begin
            sel_d = wdata[SEL_W-1:0];
        end
        for (int i = 1; i < CSR_COUNT; i++) begin
            if (reg_we[i]) begin
                regs_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            regs_q <= '0;
        end else begin
            sel_q  <= sel_d;
            regs_q <= regs_d;
        end
    end
endmodule

// File: rtl/nic_csr_bank.sv
module nic_csr_bank
    import nic_csr_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    input  logic              rx_int_set,
    input  logic              tx_int_set,
    output logic              stopped,
    output logic              rx_on,
    output logic              tx_on,
    output logic [31:0]       init_ptr,
    output logic [15:0]       mode_cfg,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_PTR  = ADDR_W'(1);

    logic [DW-1:0]                csr0_q;
    logic [SEL_W-1:0]             sel_q;
    logic [CSR_COUNT-1:1][DW-1:0] aux_q;
    logic [CSR_COUNT-1:0][DW-1:0] bank;
    logic                         data_wr, ptr_wr, csr0_wr;

    assign data_wr = host_wr && (host_addr == OFS_DATA);
    assign ptr_wr  = host_wr && (host_addr == OFS_PTR);
    assign csr0_wr = data_wr && (sel_q == '0);

    nic_csr_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (csr0_wr),
        .wdata  (host_wdata),
        .rx_set (rx_int_set),
        .tx_set (tx_int_set),
        .csr0_q (csr0_q),
        .irq_q  (irq)
    );

    nic_csr_aux u_aux (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_wr  (ptr_wr),
        .data_wr (data_wr),
        .wdata   (host_wdata),
        .sel_q   (sel_q),
        .regs_q  (aux_q)
    );

    always_comb begin
        bank[0]             = csr0_q;
        bank[CSR_COUNT-1:1] = aux_q;
        host_rdata          = '0;
        if (host_addr == OFS_DATA) begin
            host_rdata = bank[sel_q];
        end else if (host_addr == OFS_PTR) begin
            host_rdata = 16'(sel_q);
        end
    end

    assign stopped  = csr0_q[B_STOP];
    assign rx_on    = csr0_q[B_RXON];
    assign tx_on    = csr0_q[B_TXON];
    assign init_ptr = {aux_q[2], aux_q[1]};
    assign mode_cfg = aux_q[3];
endmodule

// File: rtl/nic_csr_bank_chk.sv
module nic_csr_bank_chk #(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [15:0]       host_wdata,
    input logic              rx_int_set,
    input logic              tx_int_set,
    input logic              irq,
    input logic [31:0]       init_ptr,
    input logic [15:0]       csr0_view,
    input logic [1:0]        sel_view
);
    logic wr_status, wr_ptr;
    assign wr_status = host_wr && (host_addr == ADDR_W'(0)) && (sel_view == 2'd0);
    assign wr_ptr    = host_wr && (host_addr == ADDR_W'(1));

    AST_STOP_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && host_wdata[2]) |=> (csr0_view == 16'h0004)); // R4

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr && (host_wdata > 16'd3)) |=> $stable(sel_view)); // R3

    AST_INIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && host_wdata[0] && !host_wdata[2]) |=> (csr0_view[0] && csr0_view[8] && !csr0_view[2])); // R8

    AST_RX_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_int_set && !csr0_view[2] && !(wr_status && host_wdata[2])) |=> (csr0_view[10] && csr0_view[7])); // R11

    AST_TX_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_int_set && !csr0_view[2] && !(wr_status && host_wdata[2])) |=> (csr0_view[9] && csr0_view[7])); // R11

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (csr0_view[7] && csr0_view[6]) |=> irq); // R12

    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr0_view[7] && csr0_view[6]) |=> !irq); // R12

    AST_PTR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (host_addr == ADDR_W'(0)) && (sel_view == 2'd1)) |=> (init_ptr[15:0] == $past(host_wdata))); // R10
endmodule

bind nic_csr_bank nic_csr_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .rx_int_set (rx_int_set),
    .tx_int_set (tx_int_set),
    .irq        (irq),
    .init_ptr   (init_ptr),
    .csr0_view  (csr0_q),
    .sel_view   (sel_q)
);

// File: tb/nic_csr_bank_test.sv
`timescale 1ns/100ps
module nic_csr_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata;
    logic        rx_int_set = 1'b0;
    logic        tx_int_set = 1'b0;
    logic        stopped, rx_on, tx_on, irq;
    logic [31:0] init_ptr;
    logic [15:0] mode_cfg;

    int checks = 0;
    int errors = 0;
    bit live = 0;
    bit finished = 0;

    // behavioural reference state
    int m_csr0, m_sel, m_lo, m_hi, m_mode;
    bit m_irq;
    int nc;
    bit stop_w;

    always #2 clk = ~clk;

    nic_csr_bank uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rx_int_set(rx_int_set), .tx_int_set(tx_int_set),
        .stopped(stopped), .rx_on(rx_on), .tx_on(tx_on),
        .init_ptr(init_ptr), .mode_cfg(mode_cfg), .irq(irq)
    );

    task automatic check(input string req, input string what, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", req, what, got, exp, $time);
        end
    endtask

    function automatic int status_write(int cur, int wd);
        int r;
        r = cur & ~(wd & 'h7F00);
        r = r & ~('h8000 | 'h0080);
        if ((r & 'h7100) != 0) r = r | 'h8000;
        if ((r & 'h7F00) != 0) r = r | 'h0080;
        r = (r & ~'h0040) | (wd & 'h0040);
        if ((wd & 1) != 0) r = (r | 'h0101) & ~4;
        else if ((wd & 2) != 0) r = (r | 'h0032) & ~4;
        return r;
    endfunction

    function automatic int model_read(int addr);
        if (addr == 1) return m_sel;
        if (addr != 0) return 0;
        case (m_sel)
            0: return m_csr0;
            1: return m_lo;
            2: return m_hi;
            default: return m_mode;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_csr0 = 4; m_sel = 0; m_lo = 0; m_hi = 0; m_mode = 0; m_irq = 0;
        end else begin
            m_irq = ((m_csr0 & 'h80) != 0) && ((m_csr0 & 'h40) != 0);
            nc = m_csr0;
            stop_w = 0;
            if (host_wr && host_addr == 2'd1) begin
                if (host_wdata < 16'd4) m_sel = int'(host_wdata);
            end else if (host_wr && host_addr == 2'd0) begin
                case (m_sel)
                    0: begin
                        if (host_wdata[2]) begin stop_w = 1; nc = 4; end
                        else nc = status_write(m_csr0, int'(host_wdata));
                    end
                    1: m_lo = int'(host_wdata);
                    2: m_hi = int'(host_wdata);
                    default: m_mode = int'(host_wdata);
                endcase
            end
            if (!stop_w && (m_csr0 & 4) == 0) begin
                if (rx_int_set) nc = nc | 'h0480;
                if (tx_int_set) nc = nc | 'h0280;
            end
            m_csr0 = nc;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (live && rst_n) begin
            check("R2", "rdata", host_rdata, model_read(int'(host_addr)));
            check("R9", "stopped", stopped, (m_csr0 >> 2) & 1);
            check("R9", "rx_on", rx_on, (m_csr0 >> 5) & 1);
            check("R9", "tx_on", tx_on, (m_csr0 >> 4) & 1);
            check("R10", "init_ptr", init_ptr, (longint'(m_hi) << 16) | m_lo);
            check("R10", "mode_cfg", mode_cfg, m_mode);
            check("R12", "irq", irq, m_irq);
        end
    end

    task automatic drive(input bit wr, input int addr, input int wd, input bit rx, input bit tx);
        @(posedge clk);
        #1;
        host_wr = wr; host_addr = 2'(addr); host_wdata = 16'(wd);
        rx_int_set = rx; tx_int_set = tx;
    endtask

    task automatic peek(input string req, input int addr, input int exp);
        drive(0, addr, 0, 0, 0);
        #0.5;
        check(req, "read", host_rdata, exp);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        live = 1;
        // R1 reset state
        peek("R1", 0, 'h0004);
        peek("R1", 1, 0);
        check("R1", "irq", irq, 0);
        check("R1", "init_ptr", init_ptr, 0);
        // R2 unused offsets
        peek("R2", 2, 0);
        peek("R2", 3, 0);
        // R3 pointer range
        drive(1, 1, 7, 0, 0);
        peek("R3", 1, 0);
        drive(1, 1, 3, 0, 0);
        peek("R3", 1, 3);
        drive(1, 1, 4, 0, 0);
        peek("R3", 1, 3);
        // R10 mode and init pointer
        drive(1, 0, 'h0007, 0, 0);
        peek("R10", 0, 'h0007);
        drive(1, 1, 1, 0, 0);
        drive(1, 0, 'h1234, 0, 0);
        drive(1, 1, 2, 0, 0);
        drive(1, 0, 'hABCD, 0, 0);
        peek("R10", 0, 'hABCD);
        check("R10", "init_ptr", init_ptr, 'hABCD1234);
        check("R10", "mode_cfg", mode_cfg, 'h0007);
        drive(1, 1, 0, 0, 0);
        // R11 strobes ignored while stopped
        drive(0, 0, 0, 1, 1);
        peek("R11", 0, 'h0004);
        // R8 init from stopped, R7 enable
        drive(1, 0, 'h0043, 0, 0);
        peek("R8", 0, 'h0141);
        // R9 start; R6 summaries now include bit 8
        drive(1, 0, 'h0042, 0, 0);
        peek("R9", 0, 'h81F3);
        check("R12", "irq lag", irq, 0);
        peek("R12", 0, 'h81F3);
        check("R12", "irq", irq, 1);
        // R5 clear init-done, R6 summaries drop
        drive(1, 0, 'h0140, 0, 0);
        peek("R5", 0, 'h0073);
        peek("R6", 0, 'h0073);
        check("R12", "irq fall", irq, 0);
        // R11 transmit event
        drive(0, 0, 0, 0, 1);
        peek("R11", 0, 'h02F3);
        // R11 set beats clear
        drive(1, 0, 'h0640, 1, 0);
        peek("R11", 0, 'h04F3);
        // R7 enable cleared, summary kept
        drive(1, 0, 'h0000, 0, 0);
        peek("R7", 0, 'h04B3);
        // R6 error summary from bit 8
        drive(1, 0, 'h0001, 0, 0);
        peek("R8", 0, 'h05B3);
        drive(1, 0, 'h0000, 0, 0);
        peek("R6", 0, 'h85B3);
        // R4 stop overrides everything
        drive(1, 0, 'h7F47, 1, 1);
        peek("R4", 0, 'h0004);
        // random traffic against the model
        for (int i = 0; i < 600; i++) begin
            int a, w;
            a = int'($urandom % 4);
            w = int'($urandom & 'hFFFF);
            if (a == 1) w = int'($urandom % 8);
            if ((w & 4) != 0 && ($urandom % 5) != 0) w = w & ~4;
            if (($urandom % 6) == 0) w = w | 3;
            drive(($urandom % 3) == 0, a, w, ($urandom % 5) == 0, ($urandom % 5) == 0);
        end
        drive(0, 0, 0, 0, 0);
        @(posedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule